// File: doc/BRIEF.md
# Second-Order CDR Loop Filter

This block is the digital loop filter and phase accumulator of a clock and data recovery loop that steers a phase interpolator. On every update cycle it takes a small signed early/late phase error from an external phase detector. It sends that error down two paths. The proportional path scales the error by a programmable power-of-two gain and adds it straight into a phase accumulator. The integral path scales it by a second power-of-two gain and adds it into a frequency register. The frequency register is then fed into the phase accumulator on every later update. The top bits of the phase accumulator form the interpolator code, which wraps around freely.

A runtime select picks the loop order. In second-order mode the frequency register learns a constant frequency offset between the incoming data and the local clock, so the residual phase error settles to within one interpolator step. The register value is also available as a frequency-offset estimate. In first-order mode the integral path is switched off, and a constant offset leaves a steady phase error whose size grows with the offset and shrinks with the proportional gain. A hold input freezes the loop while the detector output is not valid. A synchronous reset clears both accumulators.

Top module: `cdr_loop_filter`

## Requirements
- R1: While `rst` is high at a rising edge, `freq_est` and the phase accumulator, and therefore `pi_code`, become zero at that edge.
- R2: Each update (rising edge with `rst` and `hold` low) adds the proportional term `(pd_err * 2^FRAC_W) >>> kp_shift` (arithmetic shift) to the PH_W-bit phase accumulator. `pi_code` is its top PI_W bits, so one code step equals 2^FRAC_W accumulator units.
- R3: In second-order mode (`first_order` = 0) each update adds `(pd_err * 2^FRAC_W) >>> ki_shift` to `freq_est`. The phase accumulator adds the value `freq_est` held before that update.
- R4: `freq_est` saturates at the signed limits of FREQ_W bits (8191 and -8192 by default) instead of wrapping.
- R5: With `first_order` = 1 an update forces `freq_est` to zero, and the phase accumulator receives the proportional term only.
- R6: While `hold` is high (and `rst` low), `pi_code` and `freq_est` do not change, whatever `pd_err` is.
- R7: The phase accumulator, and with it `pi_code`, rolls over modulo 2^PH_W with no saturation or stall. For example, 19 updates of +7 code steps from 0 give code 5.
- R8: In second-order mode with a constant data phase drift inside the capture range, the closed loop settles. Each measured phase error then lies within one code step, and `freq_est` averages to the drift in accumulator units per update.
- R9: In first-order mode with a constant drift, the steady phase error stays nonzero with the sign of the drift. Its mean times the proportional gain equals the drift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update clock; one update per rising edge |
| rst | input | 1 | Synchronous active-high reset of both accumulators |
| hold | input | 1 | Freeze both accumulators (phase error invalid) |
| first_order | input | 1 | 1 = first-order loop, 0 = second-order loop (default) |
| pd_err | input | ERR_W | Signed phase error in interpolator steps, late positive |
| kp_shift | input | SH_W | Proportional gain as right shift of the scaled error |
| ki_shift | input | SH_W | Integral gain as right shift of the scaled error |
| pi_code | output | PI_W | Wrapping phase-interpolator code (registered) |
| freq_est | output | FREQ_W | Signed frequency register, offset estimate (registered) |

## Verification
Both outputs come straight from registers. An update applied before a rising edge shows on `pi_code` and `freq_est` right after that edge, and the `freq_est` value that reaches the phase path shows one edge later. The bench drives every input on the falling edge and samples 1 ns after the next rising edge, so each table row and each directed step is checked exactly one update after it is applied. The closed-loop runs feed the phase error back from the sampled code at the following falling edge. They judge only a window of 256 updates after settling, using averages whose bounds follow from phase balance over that window.

// File: rtl/cdr_lf_pkg.sv
package cdr_lf_pkg;
  // Loop order select, encoded as driven on the first_order pin
  typedef enum logic {
    LOOP_SECOND = 1'b0,
    LOOP_FIRST  = 1'b1
  } loop_order_e;
endpackage

// File: rtl/cdr_gain_shift.sv
// Scales a small signed error up to accumulator units, then applies a
// power-of-two gain as an arithmetic right shift.
module cdr_gain_shift #(
  parameter int ERR_W  = 4,
  parameter int FRAC_W = 10,
  parameter int SH_W   = 4,
  localparam int TERM_W = ERR_W + FRAC_W
) (
  input  logic signed [ERR_W-1:0]  err,
  input  logic        [SH_W-1:0]   shift,
  output logic signed [TERM_W-1:0] term
);
  logic signed [TERM_W-1:0] scaled;

  assign scaled = TERM_W'(err) <<< FRAC_W;
  assign term   = scaled >>> shift;
endmodule

// File: rtl/cdr_freq_integ.sv
// Integral path register with signed saturation.
module cdr_freq_integ #(
  parameter int TERM_W = 14,
  parameter int FREQ_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hold,
  input  logic                     clear,
  input  logic signed [TERM_W-1:0] term,
  output logic signed [FREQ_W-1:0] freq_q
);
  localparam int SUM_W = ((TERM_W > FREQ_W) ? TERM_W : FREQ_W) + 1;
  localparam logic signed [SUM_W-1:0] F_MAX =
    SUM_W'((64'sd1 <<< (FREQ_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] F_MIN = ~F_MAX;

  logic signed [SUM_W-1:0]  sum;
  logic signed [FREQ_W-1:0] freq_d;

  assign sum = SUM_W'(freq_q) + SUM_W'(term);

  always_comb begin
    if (sum > F_MAX)      freq_d = FREQ_W'(F_MAX);
    else if (sum < F_MIN) freq_d = FREQ_W'(F_MIN);
    else                  freq_d = FREQ_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst)        freq_q <= '0;
    else if (hold)  freq_q <= freq_q;
    else if (clear) freq_q <= '0;
    else            freq_q <= freq_d;
  end
endmodule

// File: rtl/cdr_phase_acc.sv
// Wrapping phase accumulator; its top bits drive the interpolator.
module cdr_phase_acc #(
  parameter int TERM_W = 14,
  parameter int FREQ_W = 14,
  parameter int PH_W   = 17,
  parameter int PI_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hold,
  input  logic                     use_freq,
  input  logic signed [TERM_W-1:0] prop_term,
  input  logic signed [FREQ_W-1:0] freq_q,
  output logic        [PI_W-1:0]   pi_code
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] prop_ext;
  logic [PH_W-1:0] freq_ext;
  logic [PH_W-1:0] inc;

  assign prop_ext = PH_W'(prop_term);
  assign freq_ext = use_freq ? PH_W'(freq_q) : '0;
  assign inc      = prop_ext + freq_ext;

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= '0;
    else if (hold) phase_q <= phase_q;
    else           phase_q <= phase_q + inc;
  end

  assign pi_code = phase_q[PH_W-1 -: PI_W];
endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter #(
  parameter int ERR_W  = 4,
  parameter int PI_W   = 7,
  parameter int FRAC_W = 10,
  parameter int FREQ_W = 14,
  parameter int SH_W   = 4,
  localparam int PH_W   = PI_W + FRAC_W,
  localparam int TERM_W = ERR_W + FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hold,
  input  logic                     first_order,
  input  logic signed [ERR_W-1:0]  pd_err,
  input  logic        [SH_W-1:0]   kp_shift,
  input  logic        [SH_W-1:0]   ki_shift,
  output logic        [PI_W-1:0]   pi_code,
  output logic signed [FREQ_W-1:0] freq_est
);
  import cdr_lf_pkg::*;

  loop_order_e              mode;
  logic signed [TERM_W-1:0] prop_term;
  logic signed [TERM_W-1:0] int_term;

  assign mode = loop_order_e'(first_order);

  cdr_gain_shift #(.ERR_W(ERR_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_prop (
    .err(pd_err), .shift(kp_shift), .term(prop_term)
  );

  cdr_gain_shift #(.ERR_W(ERR_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_integ_gain (
    .err(pd_err), .shift(ki_shift), .term(int_term)
  );

  cdr_freq_integ #(.TERM_W(TERM_W), .FREQ_W(FREQ_W)) u_freq (
    .clk(clk), .rst(rst), .hold(hold),
    .clear(mode == LOOP_FIRST),
    .term(int_term), .freq_q(freq_est)
  );

  cdr_phase_acc #(.TERM_W(TERM_W), .FREQ_W(FREQ_W), .PH_W(PH_W), .PI_W(PI_W)) u_phase (
    .clk(clk), .rst(rst), .hold(hold),
    .use_freq(mode == LOOP_SECOND),
    .prop_term(prop_term), .freq_q(freq_est), .pi_code(pi_code)
  );
endmodule

// File: rtl/cdr_loop_filter_chk.sv
module cdr_loop_filter_chk #(
  parameter int ERR_W  = 4,
  parameter int PI_W   = 7,
  parameter int FREQ_W = 14
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     hold,
  input logic                     first_order,
  input logic signed [ERR_W-1:0]  pd_err,
  input logic        [PI_W-1:0]   pi_code,
  input logic signed [FREQ_W-1:0] freq_est
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (freq_est == '0 && pi_code == '0));

  assert_zero_err_still_R2: assert property (@(posedge clk) disable iff (rst)
    (first_order && !hold && pd_err == '0) |=> $stable(pi_code));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (!first_order && !hold && pd_err < 0) |=> (freq_est <= $past(freq_est)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!first_order && !hold && pd_err > 0) |=> (freq_est >= $past(freq_est)));

  assert_first_order_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (first_order && !hold) |=> (freq_est == '0));

  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(freq_est) && $stable(pi_code)));
endmodule

bind cdr_loop_filter cdr_loop_filter_chk #(
  .ERR_W(ERR_W), .PI_W(PI_W), .FREQ_W(FREQ_W)
) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .first_order(first_order),
  .pd_err(pd_err), .pi_code(pi_code), .freq_est(freq_est)
);

// File: tb/cdr_loop_filter_bench.sv
module cdr_loop_filter_bench;
  localparam int ERR_W = 4, PI_W = 7, FRAC_W = 10, FREQ_W = 14, SH_W = 4;
  localparam int PH_MASK = (1 << (PI_W + FRAC_W)) - 1;
  localparam int WIN = 256;

  logic clk = 1'b0, rst = 1'b1, hold = 1'b0, first_order = 1'b0;
  logic signed [ERR_W-1:0] pd_err = '0;
  logic [SH_W-1:0] kp_shift = '0, ki_shift = '0;
  logic [PI_W-1:0] pi_code;
  logic signed [FREQ_W-1:0] freq_est;

  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  cdr_loop_filter u_cdr_loop_filter (
    .clk(clk), .rst(rst), .hold(hold), .first_order(first_order),
    .pd_err(pd_err), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .pi_code(pi_code), .freq_est(freq_est)
  );

  typedef struct packed {
    logic              fo;
    logic              hd;
    logic signed [3:0] err;
    logic [3:0]        kp;
    logic [3:0]        ki;
    logic [6:0]        code;
    logic signed [13:0] freq;
  } vec_t;

  // Applied in order from reset; expected outputs one edge later.
  localparam vec_t VECS [0:10] = '{
    '{1'b0, 1'b0,  4'sd3, 4'd2, 4'd4, 7'd0,     14'sd192},   // R2 R3
    '{1'b0, 1'b0,  4'sd2, 4'd2, 4'd4, 7'd1,     14'sd320},   // R3 old freq into phase
    '{1'b0, 1'b1,  4'sd7, 4'd0, 4'd0, 7'd1,     14'sd320},   // R6 hold
    '{1'b0, 1'b0, -4'sd4, 4'd1, 4'd3, 7'd127,  -14'sd192},   // R7 wrap below zero
    '{1'b0, 1'b0,  4'sd0, 4'd1, 4'd3, 7'd127,  -14'sd192},   // R3
    '{1'b1, 1'b0,  4'sd1, 4'd0, 4'd3, 7'd0,     14'sd0},     // R5 first order
    '{1'b1, 1'b0, -4'sd1, 4'd0, 4'd3, 7'd127,   14'sd0},     // R5
    '{1'b0, 1'b0, -4'sd1, 4'd0, 4'd0, 7'd126,  -14'sd1024},  // R3
    '{1'b0, 1'b0, -4'sd8, 4'd0, 4'd0, 7'd117,  -14'sd8192},  // R4 negative limit
    '{1'b0, 1'b0, -4'sd8, 4'd0, 4'd0, 7'd101,  -14'sd8192},  // R4 stays at limit
    '{1'b0, 1'b0,  4'sd7, 4'd0, 4'd0, 7'd100,  -14'sd1024}   // R3 leaves limit
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_true(input string req, input string what, input bit ok, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input bit fo, input bit hd, input int err, input int kp, input int ki);
    @(negedge clk);
    first_order = fo; hold = hd;
    pd_err = ERR_W'(err); kp_shift = SH_W'(kp); ki_shift = SH_W'(ki);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hold = 1'b0; pd_err = '0;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Closed loop: data phase drifts by d accumulator units per update.
  task automatic run_loop(input bit fo, input int d, input int kp, input int ki, input int cycles,
                          output int sum_e, output int max_abs_e, output int sum_f);
    int data = 0;
    sum_e = 0; max_abs_e = 0; sum_f = 0;
    do_reset();
    for (int i = 0; i < cycles; i++) begin
      int diff;
      @(negedge clk);
      diff = ((data >> FRAC_W) & ((1 << PI_W) - 1)) - int'(pi_code);
      if (diff >= (1 << (PI_W - 1)))  diff -= (1 << PI_W);
      if (diff < -(1 << (PI_W - 1))) diff += (1 << PI_W);
      if (diff > 7)  diff = 7;
      if (diff < -8) diff = -8;
      first_order = fo; hold = 1'b0;
      pd_err = ERR_W'(diff); kp_shift = SH_W'(kp); ki_shift = SH_W'(ki);
      if (i >= cycles - WIN) begin
        sum_e += diff;
        if ((diff < 0 ? -diff : diff) > max_abs_e) max_abs_e = (diff < 0 ? -diff : diff);
      end
      @(posedge clk); #1;
      data = (data + d) & PH_MASK;
      if (i >= cycles - WIN) sum_f += int'(freq_est);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int se, me, sf;
    do_reset();
    check("R1", "code after reset", int'(pi_code), 0);
    check("R1", "freq after reset", int'(freq_est), 0);

    foreach (VECS[k]) begin
      apply(VECS[k].fo, VECS[k].hd, int'(VECS[k].err), int'(VECS[k].kp), int'(VECS[k].ki));
      check("R2-table", $sformatf("row %0d code", k), int'(pi_code), int'(VECS[k].code));
      check("R3-table", $sformatf("row %0d freq", k), int'(freq_est), int'(VECS[k].freq));
    end

    // R4: positive saturation
    do_reset();
    apply(1'b0, 1'b0, 7, 0, 0);
    apply(1'b0, 1'b0, 7, 0, 0);
    check("R4", "freq at upper limit", int'(freq_est), 8191);
    check("R2", "code with old freq", int'(pi_code), 21);
    apply(1'b0, 1'b0, -1, 0, 0);
    check("R4", "freq leaves upper limit", int'(freq_est), 7167);

    // R7: rollover in first-order mode, +7 steps per update
    do_reset();
    for (int i = 0; i < 18; i++) apply(1'b1, 1'b0, 7, 0, 0);
    check("R7", "code before wrap", int'(pi_code), 126);
    apply(1'b1, 1'b0, 7, 0, 0);
    check("R7", "code after wrap", int'(pi_code), 5);

    // R6: hold with large error
    apply(1'b1, 1'b1, -8, 0, 0);
    check("R6", "code frozen", int'(pi_code), 5);

    // R1: mid-run reset wins over hold
    @(negedge clk); rst = 1'b1; hold = 1'b1;
    @(posedge clk); #1;
    check("R1", "code after mid-run reset", int'(pi_code), 0);
    @(negedge clk); rst = 1'b0; hold = 1'b0;

    // R8: second-order tracking, positive and negative drift
    run_loop(1'b0, 300, 2, 6, 3000, se, me, sf);
    check_true("R8", "max residual error (+drift)", me <= 1, me, 1);
    check_true("R8", "mean freq (+drift)", (sf / WIN >= 236) && (sf / WIN <= 364), sf / WIN, 300);
    run_loop(1'b0, -450, 2, 6, 3000, se, me, sf);
    check_true("R8", "max residual error (-drift)", me <= 1, me, 1);
    check_true("R8", "mean freq (-drift)", (sf / WIN >= -514) && (sf / WIN <= -386), sf / WIN, -450);

    // R9: first-order steady error, sum over window equals drift (kp_shift 2)
    run_loop(1'b1, 300, 2, 6, 2000, se, me, sf);
    check_true("R9", "error sum (+drift)", (se >= 284) && (se <= 316), se, 300);
    check("R5", "freq stays zero in first order", sf, 0);
    run_loop(1'b1, -200, 2, 6, 2000, se, me, sf);
    check_true("R9", "error sum (-drift)", (se >= -216) && (se <= -184), se, -200);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule